// File: doc/BRIEF.md
# Floppy Card Bit-Control Register with Motor Hold Timer

This block is the bit-addressed control and status port of a floppy disk card. The host writes one bit at a time. Each write carries an address and a single data bit. Address bits 15:8 must match the card's base, and address bits 3:1 choose which of eight control bits is written. The block keeps the card-select, wait-enable, head-load and side-select bits, and three drive-select bits. It also reports an 8-bit status byte, which is read back through the same address bus.

One write location is a motor trigger. Only a 0-to-1 change of that bit starts, or restarts, a hold timer. While the timer runs, a single motor-enable line is driven high. That line goes to all three drives and also forces the controller's ready input. The timer length is a fixed number of milliseconds and is counted in clock cycles from a clock-frequency parameter. The three drive-select bits are resolved into a one-hot drive choice with a valid flag. When more than one bit is set, the highest-numbered drive wins.

Top module: `flopctl_top`

## Requirements
- R1: A write takes effect only when `wrEn` is high and `busAddr[15:8]` equals `BASE` (default 8'h11). The bit index is `busAddr[3:1]`. Address bits 7:4 and bit 0 have no effect. A write with any other base changes no output.
- R2: Writes to indexes 0, 2, 3 and 7 store `wrBit` into `cardSel`, `waitEn`, `headLoad` and `sideSel`. Writes to indexes 4, 5 and 6 store `wrBit` into drive-select bits 0, 1 and 2. Each new value is visible on the outputs in the cycle after the write edge.
- R3: A write of 1 to index 1, when the stored trigger bit is 0, raises `motorEn` in the cycle after the write edge. `motorEn` then stays high for exactly HOLD = CLK_HZ/1000*WINDOW_MS cycles, unless it is retriggered.
- R4: A write of 1 to index 1 while the stored trigger bit is already 1 does not start or extend the window. A write of 0 to index 1 does not stop a running window.
- R5: While `motorEn` is high, all three bits of `driveMotorOn` are 1. When the window expires, `motorEn` and every bit of `driveMotorOn` drop to 0.
- R6: `statusOut` is 0 unless `busAddr[15:8]` equals `BASE` and `busAddr[3:1]` is 0. When selected, the status bits are:
  - bit 0: `headLoad`
  - bits 3:1: drive-select bits 2:0
  - bit 4: the inverse of `motorEn`
  - bit 5: 0
  - bit 6: 1
  - bit 7: `sideSel`
- R7: `driveOneHot` has bit i set only when drive-select bit i is set and no higher drive-select bit is set. `driveValid` is high when any drive-select bit is set. With no bit set, `driveOneHot` is 0.
- R8: While `rst_n` is low, all stored bits, the stored trigger bit and the timer are cleared. After reset, the first write of 1 to index 1 starts a window.
- R9: A new 0-to-1 trigger during a running window reloads the full HOLD count from that write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Bit address for writes and for status selection |
| wrEn | input | 1 | Single-bit write strobe |
| wrBit | input | 1 | Data bit to write |
| cardSel | output | 1 | Card select bit |
| waitEn | output | 1 | Wait-state enable bit |
| headLoad | output | 1 | Head load bit |
| sideSel | output | 1 | Side select bit |
| motorEn | output | 1 | Shared motor enable, also the forced-ready line |
| driveMotorOn | output | 3 | Per-drive motor-on outputs |
| driveOneHot | output | 3 | Resolved drive select, highest set bit wins |
| driveValid | output | 1 | At least one drive selected |
| statusOut | output | 8 | Status byte, zero when not addressed |

## Verification
Every stored control bit, the drive resolution and the rise of `motorEn` are due one cycle after the write edge. The status byte is combinational on `busAddr`. The bench drives inputs at the falling edge and compares at the next falling edge, so every register result is sampled a half cycle after it settles. The end of the motor window is due HOLD cycles after the trigger edge. The bench counts rising edges from the trigger and checks `motorEn` at HOLD-1 cycles, where it must still be high, and at HOLD cycles, where it must be low. A cycle model in the bench also tracks the expected timer through random writes, and the outputs are compared against it at every falling edge.

// File: rtl/flopctl_pkg.sv
package flopctl_pkg;
  localparam int DRIVES = 3;

  typedef struct packed {
    logic                setCard;
    logic                setMotor;
    logic                setWait;
    logic                setHead;
    logic [DRIVES-1:0]   setDrive;
    logic                setSide;
    logic                val;
  } bitStrobe_t;
endpackage

// File: rtl/flopctl_ctrl.sv
module flopctl_ctrl
  import flopctl_pkg::*;
#(
  parameter logic [7:0] BASE = 8'h11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] busAddr,
  input  logic        wrEn,
  input  logic        wrBit,
  output bitStrobe_t  strb,
  output logic        statusSel
);
  logic       baseHit;
  logic [2:0] bitIdx;

  assign baseHit   = (busAddr[15:8] == BASE);
  assign bitIdx    = busAddr[3:1];
  assign statusSel = baseHit && (bitIdx == 3'd0);

  always_comb begin
    strb     = '0;
    strb.val = wrBit;
    if (wrEn && baseHit) begin
      case (bitIdx)
        3'd0: strb.setCard     = 1'b1;
        3'd1: strb.setMotor    = 1'b1;
        3'd2: strb.setWait     = 1'b1;
        3'd3: strb.setHead     = 1'b1;
        3'd4: strb.setDrive[0] = 1'b1;
        3'd5: strb.setDrive[1] = 1'b1;
        3'd6: strb.setDrive[2] = 1'b1;
        default: strb.setSide  = 1'b1;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.setCard, strb.setMotor, strb.setWait, strb.setHead,
              strb.setDrive, strb.setSide})); // R1
endmodule

// File: rtl/flopctl_dp.sv
module flopctl_dp
  import flopctl_pkg::*;
#(
  parameter int HOLD_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bitStrobe_t        strb,
  input  logic              statusSel,
  output logic              cardSel,
  output logic              waitEn,
  output logic              headLoad,
  output logic              sideSel,
  output logic              motorEn,
  output logic [DRIVES-1:0] driveMotorOn,
  output logic [DRIVES-1:0] driveOneHot,
  output logic              driveValid,
  output logic [7:0]        statusOut
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [DRIVES-1:0] dsel;
  logic              prevMotor;
  logic [CW-1:0]     holdCnt;
  logic              motorKick;

  assign motorKick = strb.setMotor && strb.val && !prevMotor;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cardSel   <= 1'b0;
      waitEn    <= 1'b0;
      headLoad  <= 1'b0;
      sideSel   <= 1'b0;
      dsel      <= '0;
      prevMotor <= 1'b0;
      holdCnt   <= '0;
    end else begin
      if (strb.setCard)  cardSel   <= strb.val;
      if (strb.setWait)  waitEn    <= strb.val;
      if (strb.setHead)  headLoad  <= strb.val;
      if (strb.setSide)  sideSel   <= strb.val;
      if (strb.setMotor) prevMotor <= strb.val;
      for (int i = 0; i < DRIVES; i++)
        if (strb.setDrive[i]) dsel[i] <= strb.val;
      if (motorKick)             holdCnt <= CW'(HOLD_CYC);
      else if (holdCnt != '0)    holdCnt <= holdCnt - 1'b1;
    end
  end

  assign motorEn      = (holdCnt != '0);
  assign driveMotorOn = {DRIVES{motorEn}};

  // Highest-numbered selected drive wins
  for (genvar i = 0; i < DRIVES; i++) begin : g_prio
    if (i == DRIVES - 1) begin : g_top
      assign driveOneHot[i] = dsel[i];
    end else begin : g_low
      assign driveOneHot[i] = dsel[i] & ~(|dsel[DRIVES-1:i+1]);
    end
  end
  assign driveValid = |dsel;

  assign statusOut = statusSel ? {sideSel, 1'b1, 1'b0, ~motorEn, dsel, headLoad} : 8'h00;

  AST_KICK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.setMotor && strb.val && !prevMotor) |=> (holdCnt == CW'(HOLD_CYC))); // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.setMotor && prevMotor && holdCnt != '0) |=> (holdCnt == CW'($past(holdCnt) - 1'b1))); // R4
  AST_EXPIRE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (holdCnt == CW'(1) && !strb.setMotor) |=> (driveMotorOn == '0)); // R5
  AST_ONEHOT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(driveOneHot)); // R7
  AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    dsel[DRIVES-1] |-> driveOneHot[DRIVES-1]); // R7
  AST_STATUS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    statusSel |-> (statusOut[6:5] == 2'b10)); // R6
endmodule

// File: rtl/flopctl_top.sv
module flopctl_top
  import flopctl_pkg::*;
#(
  parameter int          CLK_HZ    = 50_000_000,
  parameter int          WINDOW_MS = 4230,
  parameter logic [7:0]  BASE      = 8'h11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] busAddr,
  input  logic        wrEn,
  input  logic        wrBit,
  output logic        cardSel,
  output logic        waitEn,
  output logic        headLoad,
  output logic        sideSel,
  output logic        motorEn,
  output logic [2:0]  driveMotorOn,
  output logic [2:0]  driveOneHot,
  output logic        driveValid,
  output logic [7:0]  statusOut
);
  localparam int HOLD_CYC = CLK_HZ / 1000 * WINDOW_MS;

  bitStrobe_t strb;
  logic       statusSel;

  flopctl_ctrl #(.BASE(BASE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .wrEn(wrEn), .wrBit(wrBit),
    .strb(strb), .statusSel(statusSel)
  );

  flopctl_dp #(.HOLD_CYC(HOLD_CYC)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .statusSel(statusSel),
    .cardSel(cardSel), .waitEn(waitEn), .headLoad(headLoad), .sideSel(sideSel),
    .motorEn(motorEn), .driveMotorOn(driveMotorOn), .driveOneHot(driveOneHot),
    .driveValid(driveValid), .statusOut(statusOut)
  );
endmodule

// File: tb/sim_flopctl_top.sv
module sim_flopctl_top;
  localparam int CLK_HZ    = 5000;
  localparam int WINDOW_MS = 4230;
  localparam int H         = CLK_HZ / 1000 * WINDOW_MS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] busAddr = 16'h0000;
  logic        wrEn = 1'b0;
  logic        wrBit = 1'b0;
  logic        cardSel, waitEn, headLoad, sideSel, motorEn, driveValid;
  logic [2:0]  driveMotorOn, driveOneHot;
  logic [7:0]  statusOut;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  flopctl_top #(.CLK_HZ(CLK_HZ), .WINDOW_MS(WINDOW_MS), .BASE(8'h11)) u0 (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .wrEn(wrEn), .wrBit(wrBit),
    .cardSel(cardSel), .waitEn(waitEn), .headLoad(headLoad), .sideSel(sideSel),
    .motorEn(motorEn), .driveMotorOn(driveMotorOn), .driveOneHot(driveOneHot),
    .driveValid(driveValid), .statusOut(statusOut)
  );

  // Requirement-level model, advanced at each rising edge
  logic       mCard, mWait, mHead, mSide, mPrev;
  logic [2:0] mDsel;
  int         mRem;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      mCard = 0; mWait = 0; mHead = 0; mSide = 0; mPrev = 0; mDsel = 0; mRem = 0;
    end else begin
      if (mRem != 0) mRem = mRem - 1;
      if (wrEn && busAddr[15:8] == 8'h11) begin
        case (busAddr[3:1])
          3'd0: mCard = wrBit;
          3'd1: begin
            if (wrBit && !mPrev) mRem = H;
            mPrev = wrBit;
          end
          3'd2: mWait = wrBit;
          3'd3: mHead = wrBit;
          3'd4: mDsel[0] = wrBit;
          3'd5: mDsel[1] = wrBit;
          3'd6: mDsel[2] = wrBit;
          default: mSide = wrBit;
        endcase
      end
    end
  end

  function automatic logic [2:0] expOneHot(input logic [2:0] d);
    if (d[2]) return 3'b100;
    if (d[1]) return 3'b010;
    if (d[0]) return 3'b001;
    return 3'b000;
  endfunction

  function automatic logic [7:0] expStatus(input logic [15:0] a);
    if (a[15:8] != 8'h11 || a[3:1] != 3'd0) return 8'h00;
    return {mSide, 1'b1, 1'b0, (mRem == 0), mDsel, mHead};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic checkModel(input string tag);
    chk({tag, " R2 bits"}, {cardSel, waitEn, headLoad, sideSel}, {mCard, mWait, mHead, mSide});
    chk({tag, " R3 motorEn"}, motorEn, (mRem != 0));
    chk({tag, " R5 driveMotorOn"}, driveMotorOn, {3{mRem != 0}});
    chk({tag, " R7 onehot"}, {driveValid, driveOneHot}, {|mDsel, expOneHot(mDsel)});
    chk({tag, " R6 status"}, statusOut, expStatus(busAddr));
  endtask

  task automatic doWrite(input logic [15:0] a, input logic d);
    busAddr = a; wrBit = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int t0;
    int t1;
    void'($urandom(32'd1234));
    idle(3);
    rst_n = 1'b1;
    busAddr = 16'h1100;
    idle(1);

    // R8 reset state and R6 idle status
    chk("R8 reset bits", {cardSel, waitEn, headLoad, sideSel, motorEn, driveMotorOn, driveOneHot, driveValid}, 0);
    chk("R6 reset status", statusOut, 8'h50);

    // R1 off-base write ignored, ignored low address bits
    doWrite(16'h1201, 1'b1);
    chk("R1 off-base write", cardSel, 1'b0);
    doWrite(16'h11F1, 1'b1);
    chk("R1 bits 7:4 and 0 ignored", cardSel, 1'b1);

    // R2 bit map
    doWrite(16'h1104, 1'b1);
    chk("R2 wait bit", waitEn, 1'b1);
    doWrite(16'h1106, 1'b1);
    chk("R2 head bit", headLoad, 1'b1);
    doWrite(16'h110E, 1'b1);
    chk("R2 side bit", sideSel, 1'b1);

    // R7 priority
    doWrite(16'h1108, 1'b1);
    chk("R7 drive1 only", {driveValid, driveOneHot}, 4'b1001);
    doWrite(16'h110C, 1'b1);
    chk("R7 drive3 beats drive1", {driveValid, driveOneHot}, 4'b1100);
    doWrite(16'h110A, 1'b1);
    chk("R7 all set", driveOneHot, 3'b100);
    busAddr = 16'h1100;
    idle(1);
    chk("R6 status all set", statusOut, 8'hDF);
    doWrite(16'h110C, 1'b0);
    chk("R7 drive2 wins", driveOneHot, 3'b010);
    doWrite(16'h110A, 1'b0);
    doWrite(16'h1108, 1'b0);
    chk("R7 none selected", {driveValid, driveOneHot}, 4'b0000);
    busAddr = 16'h1102;
    idle(1);
    chk("R6 status not addressed", statusOut, 8'h00);

    // R3/R5 exact window
    doWrite(16'h1102, 1'b1);
    t0 = cyc;
    chk("R3 motor rises", motorEn, 1'b1);
    chk("R5 drives on", driveMotorOn, 3'b111);
    busAddr = 16'h1100;
    while (cyc < t0 + H - 1) @(negedge clk);
    chk("R3 still on at H-1", motorEn, 1'b1);
    chk("R6 status motor inverted", statusOut[4], 1'b0);
    @(negedge clk);
    chk("R3 off at H", motorEn, 1'b0);
    chk("R5 drives released", driveMotorOn, 3'b000);

    // R4 writing 1 over stored 1 does nothing
    doWrite(16'h1102, 1'b1);
    chk("R4 no start on 1-over-1", motorEn, 1'b0);
    doWrite(16'h1102, 1'b0);
    doWrite(16'h1102, 1'b1);
    t0 = cyc;
    idle(100);
    doWrite(16'h1102, 1'b1);
    doWrite(16'h1102, 1'b0);
    chk("R4 zero does not stop", motorEn, 1'b1);
    while (cyc < t0 + H - 1) @(negedge clk);
    chk("R4 on at original H-1", motorEn, 1'b1);
    @(negedge clk);
    chk("R4 off at original H", motorEn, 1'b0);

    // R9 retrigger restarts window
    doWrite(16'h1102, 1'b1);
    t0 = cyc;
    idle(3000);
    doWrite(16'h1102, 1'b0);
    doWrite(16'h1102, 1'b1);
    t1 = cyc;
    while (cyc < t0 + H) @(negedge clk);
    chk("R9 alive past first window", motorEn, 1'b1);
    while (cyc < t1 + H - 1) @(negedge clk);
    chk("R9 on at new H-1", motorEn, 1'b1);
    @(negedge clk);
    chk("R9 off at new H", motorEn, 1'b0);

    // R8 reset mid-operation; stored trigger bit cleared
    doWrite(16'h1108, 1'b1);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    busAddr = 16'h1100;
    chk("R8 cleared after reset", {cardSel, waitEn, headLoad, sideSel, driveValid, motorEn}, 0);
    doWrite(16'h1102, 1'b1);
    chk("R8 trigger bit cleared by reset", motorEn, 1'b1);

    // Random phase against the model
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if ($urandom % 4 != 0) a[15:8] = 8'h11;
      doWrite(a, 1'($urandom));
      checkModel("rand");
      for (int k = 0; k < int'($urandom % 4); k++) begin
        busAddr = ($urandom % 2) ? 16'h1100 : 16'($urandom);
        @(negedge clk);
        checkModel("rand idle");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule